// File: doc/BRIEF.md
# Standby Power Mode Controller

This controller moves a microcontroller core between three power states: run, sleep and watch. Software writes a mode control word with a sleep bit, a stop bit and a pin-state bit. The controller also takes a clock-select bit and the level of the strongest pending interrupt. From these it drives registered enables for the CPU clock, the peripheral clock, the main oscillator and the timebase timer. It also drives a pair of pin-control outputs that either hold the I/O pins at their last values or float them.

A request is recorded when the control word is written, and the state changes one clock later. A pending interrupt cancels the request, whether it is present at the write or appears in the cycle that follows. In a low-power state, any interrupt level other than "none" sends the core back to run, and a one-cycle wake pulse marks the event. Reset also returns the core to run, but it does not produce a wake pulse. Interrupt acceptance itself is handled outside this block.

Top module: `stby_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, after that edge `mode` is run (code 0), all four enables are 1, `pin_hiz` and `pin_hold` are 0, and `wake_pulse` is 0.
- R2: A write with the sleep bit at 1 and the stop bit at 0, made in run mode with `irq_level` = 7, moves `mode` to sleep (code 1) at the rising edge after the write edge.
- R3: In sleep mode `cpu_clk_en` is 0 and the other three enables are 1.
- R4: A write with the stop bit at 1 requests watch (code 2) at the edge after the write edge, but only if `clk_sel` is 0 at that edge. If `clk_sel` is 1 the request is discarded and the core stays in run. The stop bit takes precedence over the sleep bit.
- R5: In watch mode only `osc_en` and `tbt_en` are 1.
- R6: If `irq_level` is not 7 at the write edge or at the edge that follows it, the core stays in run and the request is dropped. It does not take effect once the interrupt clears.
- R7: In sleep or watch, an `irq_level` of 0 to 6 at a rising edge returns `mode` to run with all enables at 1 at that edge. `wake_pulse` is then 1 for exactly the following cycle. A level of 7 does not wake the core.
- R8: Reset asserted in sleep or watch returns the core to run with all enables on, both pin outputs at 0, and no wake pulse.
- R9: In watch mode the latched pin-state bit selects the pin behaviour: 1 gives `pin_hiz`=1 and `pin_hold`=0, and 0 gives `pin_hold`=1 and `pin_hiz`=0. Outside watch mode both are 0.
- R10: The sleep and stop requests clear on return to run, so the core stays in run until a new write, and a new write enters the state again.
- R11: Control writes made while in sleep or watch are ignored, so a stop write in sleep does not lead to watch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_sleep | input | 1 | Sleep request bit of the written word |
| ctl_stop | input | 1 | Stop request bit of the written word |
| ctl_pin_hiz | input | 1 | Pin-state bit: 1 floats pins in watch, 0 holds them |
| clk_sel | input | 1 | Clock select; 0 allows watch entry |
| irq_level | input | IRQ_W | Strongest pending interrupt level, 7 = none |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| tbt_en | output | 1 | Timebase timer enable |
| pin_hiz | output | 1 | Float I/O pins |
| pin_hold | output | 1 | Hold I/O pins at last values |
| mode | output | 2 | Current mode: 0 run, 1 sleep, 2 watch |
| wake_pulse | output | 1 | One-cycle pulse after an interrupt wake |

## Verification
A wrong mode register shows up on the enables and on `mode` at the first edge after it goes wrong. A stuck or un-cleared request bit shows up one edge after a wake as an unwanted re-entry into a low-power state. A lost or mis-latched pin-state bit shows up on the pin outputs as soon as watch is entered. Blocked-entry and write-ignore faults show up as `mode` leaving run, or changing state, one edge after the write.

// File: rtl/stby_pkg.sv
package stby_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_SLEEP = 2'd1,
        MODE_WATCH = 2'd2
    } pmode_e;

    typedef struct packed {
        logic sleep;
        logic stop;
        logic pin_hiz;
    } ctl_bits_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic tbt;
    } clk_en_t;

    localparam clk_en_t EN_ALL = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, tbt: 1'b1};

    // Clock enables belonging to each power state.
    function automatic clk_en_t enables_for(input pmode_e m);
        clk_en_t e;
        case (m)
            MODE_SLEEP: e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, tbt: 1'b1};
            MODE_WATCH: e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, tbt: 1'b1};
            default:    e = EN_ALL;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/stby_ctlreg.sv
module stby_ctlreg
    import stby_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr,
    input  ctl_bits_t wr_bits,
    input  logic      accept,
    input  logic      irq_pend,
    input  logic      clr,
    output ctl_bits_t bits_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (clr) begin
            bits_q.sleep <= 1'b0;
            bits_q.stop  <= 1'b0;
        end else if (wr && accept) begin
            bits_q.pin_hiz <= wr_bits.pin_hiz;
            // A pending interrupt at the write discards the mode request.
            bits_q.sleep   <= wr_bits.sleep && !irq_pend;
            bits_q.stop    <= wr_bits.stop && !irq_pend;
        end
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   sleep_req,
    input  logic   stop_req,
    input  logic   clk_sel,
    input  logic   irq_pend,
    output pmode_e mode_q,
    output pmode_e mode_d,
    output logic   req_clr,
    output logic   wake_q
);

    logic wake_evt;

    always_comb begin
        mode_d   = mode_q;
        req_clr  = 1'b0;
        wake_evt = 1'b0;
        case (mode_q)
            MODE_RUN: begin
                if (stop_req) begin
                    if (irq_pend || clk_sel) req_clr = 1'b1;
                    else                     mode_d  = MODE_WATCH;
                end else if (sleep_req) begin
                    if (irq_pend) req_clr = 1'b1;
                    else          mode_d  = MODE_SLEEP;
                end
            end
            MODE_SLEEP, MODE_WATCH: begin
                if (irq_pend) begin
                    mode_d   = MODE_RUN;
                    req_clr  = 1'b1;
                    wake_evt = 1'b1;
                end
            end
            default: mode_d = MODE_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_RUN;
            wake_q <= 1'b0;
        end else begin
            mode_q <= mode_d;
            wake_q <= wake_evt;
        end
    end

    assert_block_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN && irq_pend) |=> (mode_q == MODE_RUN));

    assert_wake_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_RUN && irq_pend) |=> (mode_q == MODE_RUN && wake_q));

    assert_wake_single_R7: assert property (@(posedge clk) disable iff (rst)
        wake_q |=> !wake_q);

    assert_no_sleep_to_watch_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLEEP) |=> (mode_q != MODE_WATCH));

    assert_no_watch_to_sleep_R11: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WATCH) |=> (mode_q != MODE_SLEEP));

endmodule

// File: rtl/stby_gate.sv
module stby_gate
    import stby_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  pmode_e  mode_d,
    input  logic    pin_bit,
    output clk_en_t en_q,
    output logic    pin_hiz_q,
    output logic    pin_hold_q
);

    // Enables are flops loaded from the next-state value, so they move on
    // the same edge as the mode register and never glitch.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= EN_ALL;
            pin_hiz_q  <= 1'b0;
            pin_hold_q <= 1'b0;
        end else begin
            en_q       <= enables_for(mode_d);
            pin_hiz_q  <= (mode_d == MODE_WATCH) && pin_bit;
            pin_hold_q <= (mode_d == MODE_WATCH) && !pin_bit;
        end
    end

endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int IRQ_W    = 3,
    parameter int IRQ_IDLE = (1 << IRQ_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             ctl_sleep,
    input  logic             ctl_stop,
    input  logic             ctl_pin_hiz,
    input  logic             clk_sel,
    input  logic [IRQ_W-1:0] irq_level,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             osc_en,
    output logic             tbt_en,
    output logic             pin_hiz,
    output logic             pin_hold,
    output logic [1:0]       mode,
    output logic             wake_pulse
);

    localparam logic [IRQ_W-1:0] LVL_NONE = IRQ_W'(IRQ_IDLE);

    logic      irq_pend;
    ctl_bits_t wr_bits;
    ctl_bits_t bits_q;
    pmode_e    mode_q;
    pmode_e    mode_d;
    logic      req_clr;
    logic      wake_q;
    clk_en_t   en_q;
    logic      pin_hiz_q;
    logic      pin_hold_q;

    assign irq_pend = (irq_level != LVL_NONE);
    assign wr_bits  = '{sleep: ctl_sleep, stop: ctl_stop, pin_hiz: ctl_pin_hiz};

    stby_ctlreg u_ctlreg (
        .clk      (clk),
        .rst      (rst),
        .wr       (ctl_wr),
        .wr_bits  (wr_bits),
        .accept   (mode_q == MODE_RUN),
        .irq_pend (irq_pend),
        .clr      (req_clr),
        .bits_q   (bits_q)
    );

    stby_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .sleep_req (bits_q.sleep),
        .stop_req  (bits_q.stop),
        .clk_sel   (clk_sel),
        .irq_pend  (irq_pend),
        .mode_q    (mode_q),
        .mode_d    (mode_d),
        .req_clr   (req_clr),
        .wake_q    (wake_q)
    );

    stby_gate u_gate (
        .clk        (clk),
        .rst        (rst),
        .mode_d     (mode_d),
        .pin_bit    (bits_q.pin_hiz),
        .en_q       (en_q),
        .pin_hiz_q  (pin_hiz_q),
        .pin_hold_q (pin_hold_q)
    );

    assign cpu_clk_en = en_q.cpu;
    assign per_clk_en = en_q.per;
    assign osc_en     = en_q.osc;
    assign tbt_en     = en_q.tbt;
    assign pin_hiz    = pin_hiz_q;
    assign pin_hold   = pin_hold_q;
    assign mode       = mode_q;
    assign wake_pulse = wake_q;

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (mode_q == MODE_RUN && en_q == EN_ALL && !wake_q
                 && !pin_hiz_q && !pin_hold_q));

    assert_sleep_gating_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SLEEP) |-> (!en_q.cpu && en_q.per && en_q.osc && en_q.tbt));

    assert_watch_gating_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WATCH) |-> (!en_q.cpu && !en_q.per && en_q.osc && en_q.tbt));

    assert_run_gating_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RUN) |-> (en_q == EN_ALL));

    assert_pins_watch_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_WATCH) |-> (pin_hiz_q != pin_hold_q));

    assert_pins_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MODE_WATCH) |-> (!pin_hiz_q && !pin_hold_q));

endmodule

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 28;

    typedef struct packed {
        logic       wr;
        logic       slp;
        logic       stp;
        logic       pin;
        logic       csel;
        logic [2:0] irq;
        logic [8:0] exp;   // {mode[1:0], cpu, per, osc, tbt, hiz, hold, wake}
        logic [3:0] req;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd1},  // R1 idle run
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd2},  // R2 write sleep
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b01_0111_00_0, 4'd3},  // R3 in sleep
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b01_0111_00_0, 4'd7},  // R7 level 7 no wake
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd3, 9'b00_1111_00_1, 4'd7},  // R7 wake level 3
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd7},  // R7 pulse ends
        '{1'b1,1'b0,1'b1,1'b1,1'b0,3'd7, 9'b00_1111_00_0, 4'd4},  // R4 write stop, hiz
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b10_0011_10_0, 4'd5},  // R5 in watch
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd7, 9'b10_0011_10_0, 4'd11}, // R11 write in watch
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b10_0011_10_0, 4'd9},  // R9 pins float
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd6, 9'b00_1111_00_1, 4'd7},  // R7 wake level 6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd9},  // R9 pins normal
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd2, 9'b00_1111_00_0, 4'd6},  // R6 blocked at write
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd6},  // R6 request dropped
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd6},  // R6 write sleep
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd0, 9'b00_1111_00_0, 4'd6},  // R6 irq next edge
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd6},  // R6 still run
        '{1'b1,1'b0,1'b1,1'b0,1'b1,3'd7, 9'b00_1111_00_0, 4'd4},  // R4 stop, clk_sel=1
        '{1'b0,1'b0,1'b0,1'b0,1'b1,3'd7, 9'b00_1111_00_0, 4'd4},  // R4 discarded
        '{1'b1,1'b1,1'b1,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd4},  // R4 both bits, hold
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b10_0011_01_0, 4'd9},  // R9 pins hold
        '{1'b1,1'b0,1'b1,1'b1,1'b0,3'd7, 9'b10_0011_01_0, 4'd11}, // R11 pin write ignored
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd5, 9'b00_1111_00_1, 4'd7},  // R7 wake from watch
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd10}, // R10 no re-entry
        '{1'b1,1'b1,1'b0,1'b0,1'b0,3'd7, 9'b00_1111_00_0, 4'd10}, // R10 re-arm
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b01_0111_00_0, 4'd10}, // R10 sleep again
        '{1'b1,1'b0,1'b1,1'b1,1'b0,3'd7, 9'b01_0111_00_0, 4'd11}, // R11 stop in sleep
        '{1'b0,1'b0,1'b0,1'b0,1'b0,3'd7, 9'b01_0111_00_0, 4'd11}  // R11 stays sleep
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0, ctl_sleep = 1'b0, ctl_stop = 1'b0, ctl_pin_hiz = 1'b0;
    logic       clk_sel = 1'b0;
    logic [2:0] irq_level = 3'd7;
    logic       cpu_clk_en, per_clk_en, osc_en, tbt_en, pin_hiz, pin_hold, wake_pulse;
    logic [1:0] mode;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stby_ctrl uut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_sleep(ctl_sleep),
        .ctl_stop(ctl_stop), .ctl_pin_hiz(ctl_pin_hiz), .clk_sel(clk_sel),
        .irq_level(irq_level), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .osc_en(osc_en), .tbt_en(tbt_en), .pin_hiz(pin_hiz), .pin_hold(pin_hold),
        .mode(mode), .wake_pulse(wake_pulse)
    );

    function automatic logic [8:0] outs();
        return {mode, cpu_clk_en, per_clk_en, osc_en, tbt_en, pin_hiz, pin_hold, wake_pulse};
    endfunction

    task automatic check(input string tag, input logic [8:0] exp);
        logic [8:0] act;
        act = outs();
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic slp, input logic stp,
                         input logic pin, input logic csel, input logic [2:0] irq);
        @(negedge clk);
        ctl_wr = wr; ctl_sleep = slp; ctl_stop = stp;
        ctl_pin_hiz = pin; clk_sel = csel; irq_level = irq;
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        // R1: reset state
        drive(0, 0, 0, 0, 0, 3'd7);
        drive(0, 0, 0, 0, 0, 3'd7);
        check("R1 reset", 9'b00_1111_00_0);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            drive(TBL[i].wr, TBL[i].slp, TBL[i].stp, TBL[i].pin, TBL[i].csel, TBL[i].irq);
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);
        end

        // R8: reset while in sleep (table ended in sleep)
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 3'd7);
        check("R8 reset from sleep", 9'b00_1111_00_0);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset while in watch with floating pins
        drive(1, 0, 1, 1, 0, 3'd7);
        drive(0, 0, 0, 0, 0, 3'd7);
        check("R8 watch before reset", 9'b10_0011_10_0);
        @(negedge clk);
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 3'd7);
        check("R8 reset from watch", 9'b00_1111_00_0);
        @(negedge clk);
        rst = 1'b0;
        drive(0, 0, 0, 0, 0, 3'd7);
        check("R8 stays run after reset", 9'b00_1111_00_0);

        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule